// File: doc/BRIEF.md
# Charger Mode and Standby Controller

This block is the control state machine of a single-cell battery charger. It keeps track of two operating modes. In host mode, a host processor steers the charger through control writes. In autonomous timer mode, the charger runs by itself under a long safety timer. The block decides when the charger drops into a low-power, high-impedance standby state, in which nothing is charged, and when it may leave that state. The rules for entering standby differ between the two modes.

A prescaled tick drives two timers. The first is a short low-power watchdog. It runs only while the charger sits in standby in host mode with a low battery. When it expires, the controller concludes that the host has gone away and falls back into timer mode. The second is the long charge timer of timer mode. Its expiry is reported on a sticky flag. In boost operation, a separate status output stays released. When a boost fault appears, that output is asserted for one fixed-length pulse, which is timed in system clocks.

Top module: `chg_standby_ctrl`

## Requirements
- R1: When cd_i is 1 at a clock edge, standby_o is 1 after that edge in either mode, and t15_expired_o is 0 after that edge.
- R2: In timer mode (mode_o = 1), with standby_o at 0 and cd_i at 0, a cycle with bat_ins_i = 1, bat_hi_i = 1 and vin_uv_i = 0 sets standby_o to 1. An insertion pulse with bat_hi_i = 0 leaves standby_o at 0.
- R3: In timer mode with cd_i at 0, vin_uv_i = 1 sets standby_o to 1.
- R4: In host mode (mode_o = 0) with cd_i at 0, host_sb_i = 1 sets standby_o to 1 only while otg_act_i = 0. With otg_act_i = 1, standby_o stays 0.
- R5: standby_o returns to 0 only after a cycle with cd_i = 0, vin_uv_i = 0 and host_sb_i = 0. A standby that was entered automatically in timer mode (R2, R3) is also held until a host_wr_i pulse has been seen.
- R6: t32_run_o is 1 exactly while standby_o = 1, mode_o = 0, cd_i = 0 and bat_hi_i = 0. When this condition drops, the count of the low-power timer restarts from zero.
- R7: After T32_TICKS ticks have been counted while t32_run_o = 1, mode_o becomes 1 at the edge of the last tick, and t32_run_o then reads 0.
- R8: A host_wr_i pulse sets mode_o to 0 at the next edge and restarts the low-power timer count from zero.
- R9: In timer mode, with standby_o = 0 and cd_i = 0, ticks are counted. At the edge of the T15_TICKS-th tick, t15_expired_o becomes 1 and stays 1 until cd_i is raised. Host mode clears the count.
- R10: While boost_i = 1, a rising edge on boost_flt_i raises stat_en_o for exactly PULSE_CLKS cycles, starting at that edge. Further rising edges during the pulse are ignored. stat_en_o is 0 after any edge at which boost_i = 0.
- R11: After reset, standby_o, mode_o, t32_run_o, t15_expired_o and stat_en_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle prescaled timer tick |
| cd_i | input | 1 | Charge-disable pin, 1 forces standby |
| host_sb_i | input | 1 | Host standby control bit |
| otg_act_i | input | 1 | OTG supply active |
| vin_uv_i | input | 1 | 1 when the input supply is below undervoltage |
| bat_hi_i | input | 1 | 1 when the battery is above the low threshold |
| bat_ins_i | input | 1 | One-cycle battery insertion event |
| host_wr_i | input | 1 | One-cycle pulse on any host control write |
| boost_i | input | 1 | Boost operation active |
| boost_flt_i | input | 1 | Boost fault flag |
| standby_o | output | 1 | High-impedance standby state |
| mode_o | output | 1 | 0 host mode, 1 timer mode |
| t32_run_o | output | 1 | Low-power timer is counting |
| t15_expired_o | output | 1 | Sticky charge-timer expiry |
| stat_en_o | output | 1 | Enable of the open-drain status pull-down |

## Verification
The bench interrupts the low-power timer partway through, once by raising the battery and once by a host write. The timer must then still need a full T32_TICKS ticks; a timer that only paused would switch to timer mode early. The bench also checks that an automatic standby in timer mode survives clean supply conditions until a host write. A design without this hold would leave standby on the very next cycle. Finally, the bench injects a second fault edge during a status pulse and counts the pulse length. A design that restarts the pulse on the new edge, or that lets it run on after boost ends, shows a wrong count.

// File: rtl/chg_mode_pkg.sv
package chg_mode_pkg;
   typedef enum logic {
      MODE_HOST = 1'b0,
      MODE_AUTO = 1'b1
   } chg_mode_e;
endpackage

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
   parameter int LIMIT    = 32,
   parameter bit SATURATE = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_i,
   input  logic run_i,
   input  logic tick_i,
   output logic expire_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
   localparam logic [CW-1:0] TOP  = CW'(LIMIT);

   initial begin
      assert (LIMIT >= 2) else $error("chg_tick_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          step;

   assign step     = run_i & tick_i;
   assign expire_o = step & (cnt_q == LAST);

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (rst || clr_i)
               cnt_q <= '0;
            else if (step && cnt_q != TOP)
               cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (rst || clr_i)
               cnt_q <= '0;
            else if (expire_o)
               cnt_q <= '0;
            else if (step)
               cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= TOP); // R6

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> cnt_q == '0); // R8
endmodule

// File: rtl/chg_stat_pulse.sv
module chg_stat_pulse #(
   parameter int PULSE_CLKS = 25600
) (
   input  logic clk,
   input  logic rst,
   input  logic boost_i,
   input  logic flt_i,
   output logic stat_o
);
   localparam int PW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
   localparam logic [PW-1:0] LOAD = PW'(PULSE_CLKS - 1);

   initial begin
      assert (PULSE_CLKS >= 2) else $error("chg_stat_pulse: PULSE_CLKS must be at least 2");
   end

   logic          flt_q;
   logic          stat_q;
   logic [PW-1:0] left_q;
   logic          rise;

   assign rise = flt_i & ~flt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flt_q  <= 1'b0;
         stat_q <= 1'b0;
         left_q <= '0;
      end else begin
         flt_q <= flt_i;
         if (!boost_i) begin
            stat_q <= 1'b0;
            left_q <= '0;
         end else if (!stat_q && rise) begin
            stat_q <= 1'b1;
            left_q <= LOAD;
         end else if (stat_q && left_q != '0) begin
            left_q <= left_q - 1'b1;
         end else begin
            stat_q <= 1'b0;
         end
      end
   end

   assign stat_o = stat_q;

   AST_NO_BOOST_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      !boost_i |=> !stat_o); // R10

   AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (stat_o && left_q != '0 && boost_i) |=> stat_o); // R10
endmodule

// File: rtl/chg_mode_fsm.sv
module chg_mode_fsm
   import chg_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      cd_i,
   input  logic      host_sb_i,
   input  logic      otg_act_i,
   input  logic      vin_uv_i,
   input  logic      bat_hi_i,
   input  logic      bat_ins_i,
   input  logic      host_wr_i,
   input  logic      t32_exp_i,
   input  logic      t15_exp_i,
   output logic      standby_o,
   output chg_mode_e mode_o,
   output logic      t15_flag_o
);
   logic      standby_q;
   chg_mode_e mode_q;
   logic      hold_q;
   logic      flag_q;
   logic      auto_enter;
   logic      host_enter;
   logic      exit_ok;

   always_comb begin
      auto_enter = (mode_q == MODE_AUTO) && !cd_i &&
                   ((!vin_uv_i && bat_ins_i && bat_hi_i) || vin_uv_i);
      host_enter = (mode_q == MODE_HOST) && !cd_i && host_sb_i && !otg_act_i;
      exit_ok    = !cd_i && !vin_uv_i && !host_sb_i && !hold_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         standby_q <= 1'b0;
         mode_q    <= MODE_HOST;
         hold_q    <= 1'b0;
         flag_q    <= 1'b0;
      end else begin
         if (host_wr_i)
            mode_q <= MODE_HOST;
         else if (t32_exp_i)
            mode_q <= MODE_AUTO;

         if (host_wr_i)
            hold_q <= 1'b0;
         else if (!standby_q && auto_enter)
            hold_q <= 1'b1;

         if (cd_i)
            standby_q <= 1'b1;
         else if (standby_q && exit_ok)
            standby_q <= 1'b0;
         else if (!standby_q && (auto_enter || host_enter))
            standby_q <= 1'b1;

         if (cd_i)
            flag_q <= 1'b0;
         else if (t15_exp_i)
            flag_q <= 1'b1;
      end
   end

   assign standby_o  = standby_q;
   assign mode_o     = mode_q;
   assign t15_flag_o = flag_q;

   AST_CD_FORCES_SB: assert property (@(posedge clk) disable iff (rst)
      cd_i |=> standby_o); // R1

   AST_CD_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
      cd_i |=> !t15_flag_o); // R1

   AST_OTG_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (!standby_o && !cd_i && mode_o == MODE_HOST && otg_act_i) |=> !standby_o); // R4

   AST_EXIT_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
      $fell(standby_o) |-> $past(!cd_i && !vin_uv_i && !host_sb_i)); // R5

   AST_AUTO_ONLY_BY_EXPIRY: assert property (@(posedge clk) disable iff (rst)
      (mode_o == MODE_HOST && !t32_exp_i) |=> mode_o == MODE_HOST); // R7

   AST_WR_HOST: assert property (@(posedge clk) disable iff (rst)
      host_wr_i |=> mode_o == MODE_HOST); // R8
endmodule

// File: rtl/chg_standby_ctrl.sv
module chg_standby_ctrl
   import chg_mode_pkg::*;
#(
   parameter int T32_TICKS  = 32,
   parameter int T15_TICKS  = 900,
   parameter int PULSE_CLKS = 25600
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic cd_i,
   input  logic host_sb_i,
   input  logic otg_act_i,
   input  logic vin_uv_i,
   input  logic bat_hi_i,
   input  logic bat_ins_i,
   input  logic host_wr_i,
   input  logic boost_i,
   input  logic boost_flt_i,
   output logic standby_o,
   output logic mode_o,
   output logic t32_run_o,
   output logic t15_expired_o,
   output logic stat_en_o
);
   initial begin
      assert (T15_TICKS > T32_TICKS) else $error("chg_standby_ctrl: charge timer must outlast low-power timer");
   end

   chg_mode_e mode;
   logic      standby;
   logic      t32_run, t32_clr, t32_exp;
   logic      t15_run, t15_clr, t15_exp;

   assign t32_run = standby && (mode == MODE_HOST) && !cd_i && !bat_hi_i;
   assign t32_clr = host_wr_i || !t32_run;
   assign t15_run = (mode == MODE_AUTO) && !standby && !cd_i;
   assign t15_clr = cd_i || (mode == MODE_HOST);

   chg_mode_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .cd_i       (cd_i),
      .host_sb_i  (host_sb_i),
      .otg_act_i  (otg_act_i),
      .vin_uv_i   (vin_uv_i),
      .bat_hi_i   (bat_hi_i),
      .bat_ins_i  (bat_ins_i),
      .host_wr_i  (host_wr_i),
      .t32_exp_i  (t32_exp),
      .t15_exp_i  (t15_exp),
      .standby_o  (standby),
      .mode_o     (mode),
      .t15_flag_o (t15_expired_o)
   );

   chg_tick_timer #(.LIMIT(T32_TICKS), .SATURATE(1'b0)) u_t32 (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (t32_clr),
      .run_i    (t32_run),
      .tick_i   (tick_i),
      .expire_o (t32_exp)
   );

   chg_tick_timer #(.LIMIT(T15_TICKS), .SATURATE(1'b1)) u_t15 (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (t15_clr),
      .run_i    (t15_run),
      .tick_i   (tick_i),
      .expire_o (t15_exp)
   );

   chg_stat_pulse #(.PULSE_CLKS(PULSE_CLKS)) u_stat (
      .clk     (clk),
      .rst     (rst),
      .boost_i (boost_i),
      .flt_i   (boost_flt_i),
      .stat_o  (stat_en_o)
   );

   assign standby_o = standby;
   assign mode_o    = mode;
   assign t32_run_o = t32_run;

   AST_T32_RUN_IN_SB: assert property (@(posedge clk) disable iff (rst)
      t32_run_o |-> (standby_o && !mode_o)); // R6

   AST_T32_EXP_MODE: assert property (@(posedge clk) disable iff (rst)
      (t32_exp && !host_wr_i) |=> mode_o); // R7
endmodule

// File: tb/chg_standby_ctrl_bench.sv
`timescale 1ns/1ps
module chg_standby_ctrl_bench;
   localparam int T32 = 4;
   localparam int T15 = 5;
   localparam int PCL = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 0, cd = 0, sb = 0, otg = 0, uv = 0, bh = 0, ins = 0, wr = 0;
   logic boost = 0, flt = 0;
   logic standby, mode, t32_run, t15_exp, stat;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   chg_standby_ctrl #(.T32_TICKS(T32), .T15_TICKS(T15), .PULSE_CLKS(PCL)) u_chg_standby_ctrl (
      .clk(clk), .rst(rst), .tick_i(tick), .cd_i(cd), .host_sb_i(sb),
      .otg_act_i(otg), .vin_uv_i(uv), .bat_hi_i(bh), .bat_ins_i(ins),
      .host_wr_i(wr), .boost_i(boost), .boost_flt_i(flt),
      .standby_o(standby), .mode_o(mode), .t32_run_o(t32_run),
      .t15_expired_o(t15_exp), .stat_en_o(stat)
   );

   // {cd, sb, otg, uv, bh, ins, wr, exp_standby, exp_mode}
   localparam logic [8:0] VEC [0:8] = '{
      9'b0000000_00,  // R4 idle host mode
      9'b0110000_00,  // R4 otg active blocks standby
      9'b0100000_10,  // R4 host bit enters standby
      9'b0001000_10,  // R5 undervoltage blocks exit
      9'b1000000_10,  // R1 cd high keeps standby
      9'b0100000_10,  // R5 host bit blocks exit
      9'b0000000_00,  // R5 all three met, exit
      9'b1000000_10,  // R1 cd forces standby
      9'b0000000_00   // R5 exit again
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      step();
      tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) pulse_tick();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst = 1'b0;
      step();
      // R11 reset state
      chk("R11 standby", standby, 1'b0);
      chk("R11 mode", mode, 1'b0);
      chk("R11 t32_run", t32_run, 1'b0);
      chk("R11 t15_expired", t15_exp, 1'b0);
      chk("R11 stat", stat, 1'b0);

      for (int i = 0; i < 9; i++) begin
         {cd, sb, otg, uv, bh, ins, wr} = VEC[i][8:2];
         step();
         chk($sformatf("R4/R5/R1 vec%0d standby", i), standby, VEC[i][1]);
         chk($sformatf("R8 vec%0d mode", i), mode, VEC[i][0]);
      end
      {cd, sb, otg, uv, bh, ins, wr} = '0;

      // R6 low-power timer runs in host standby with low battery
      sb = 1; bh = 0; step();
      chk("R6 run in standby", t32_run, 1'b1);
      ticks(3);
      bh = 1; step();
      chk("R6 stop on high battery", t32_run, 1'b0);
      bh = 0; step();
      ticks(3);
      chk("R6 count restarted", mode, 1'b0);
      pulse_tick();
      chk("R7 expiry to timer mode", mode, 1'b1);
      chk("R7 timer disabled", t32_run, 1'b0);

      sb = 0; bh = 1; step();
      chk("R5 exit in timer mode", standby, 1'b0);

      // R9 charge timer
      ticks(4);
      chk("R9 not yet", t15_exp, 1'b0);
      pulse_tick();
      chk("R9 expired", t15_exp, 1'b1);
      pulse_tick();
      chk("R9 sticky", t15_exp, 1'b1);

      cd = 1; step();
      chk("R1 standby", standby, 1'b1);
      chk("R1 flag cleared", t15_exp, 1'b0);
      cd = 0; step();
      chk("R5 exit after cd", standby, 1'b0);

      // R3 undervoltage entry, held until host write
      uv = 1; step();
      chk("R3 uv entry", standby, 1'b1);
      uv = 0; step(); step();
      chk("R5 auto hold", standby, 1'b1);
      wr = 1; step(); wr = 0;
      chk("R8 write to host", mode, 1'b0);
      step();
      chk("R5 exit after write", standby, 1'b0);

      // R8 write restarts low-power timer
      sb = 1; bh = 0; step();
      ticks(2);
      wr = 1; step(); wr = 0;
      ticks(3);
      chk("R8 restarted count", mode, 1'b0);
      pulse_tick();
      chk("R7 second expiry", mode, 1'b1);
      sb = 0; bh = 1; step();
      chk("R5 exit", standby, 1'b0);

      // R2 insertion entry
      ins = 1; bh = 0; step(); ins = 0;
      chk("R2 low battery insert ignored", standby, 1'b0);
      step();
      ins = 1; bh = 1; step(); ins = 0;
      chk("R2 insert entry", standby, 1'b1);
      step(); step();
      chk("R2 held", standby, 1'b1);

      // R10 boost fault pulse
      boost = 1; step();
      begin
         int hi = 0;
         flt = 1;
         for (int i = 0; i < 12; i++) begin
            if (i == 1) flt = 0;
            if (i == 2) flt = 1;
            step();
            if (stat) hi++;
         end
         checks++;
         if (hi != PCL) begin
            fails++;
            $display("FAIL R10 pulse length: actual %0d expected %0d", hi, PCL);
         end
      end
      flt = 0; boost = 0; step();
      flt = 1; step();
      chk("R10 no pulse outside boost", stat, 1'b0);
      flt = 0; boost = 1; step();
      flt = 1; step();
      chk("R10 pulse start", stat, 1'b1);
      boost = 0; step();
      chk("R10 boost drop ends pulse", stat, 1'b0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule